// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects pending-interrupt events from up to `NUM_SRC` sources (20 by default), such as a timer wrap event or external pin events, and holds them as pending flags. Each flag is qualified by a per-source enable bit and by a single global enable bit. Among the qualified sources, the one with the lowest index is chosen. When the core signals an instruction boundary, the controller issues a one-cycle take strobe to the fetch logic, together with that source's vector address.

Vector slots are two words apart and begin at word address 0x0002, so source k vectors to 0x0002 + 2*k. The last default slot is at 0x0028. Accepting an interrupt clears the global enable, which blocks nesting. For sources marked as self-clearing, acceptance also clears the serviced flag. A return-from-interrupt pulse sets the global enable again. Software programs the enable mask and the global enable, and clears flags by writing one, all through a simple register-write port.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the global enable, every enable bit, every pending flag and the take strobe are all 0.
- R2: A source is eligible only when its pending flag, its enable bit and the global enable are all 1. Nothing is taken while any of the three is 0.
- R3: An interrupt is accepted only in a cycle where `boundary_i` is 1. A pending eligible source waits while `boundary_i` is 0.
- R4: When several sources are eligible, the lowest source index is taken.
- R5: An accepted source k produces `take_o` high for exactly one cycle, registered one clock after acceptance. In that cycle `vector_o` = 0x0002 + 2*k.
- R6: Acceptance clears the global enable at the same edge. This holds even if a status write setting it lands on that edge.
- R7: A source whose bit is set in `AUTO_CLR` (default: only source 8) loses its pending flag on acceptance. Every other source's flag stays set.
- R8: Writing address 1 clears each pending flag whose data bit is 1. A set pulse in the same cycle wins over the clear.
- R9: A `reti_i` pulse sets the global enable at the next edge. An interrupt may be taken no earlier than the edge after that.
- R10: Writing address 0 loads the enable mask from data bits [NUM_SRC-1:0]. Writing address 2 loads the global enable from data bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_set_i | input | NUM_SRC | One-cycle pulses that set pending flags |
| boundary_i | input | 1 | Core is at an instruction boundary |
| reti_i | input | 1 | Return-from-interrupt pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 enable mask, 1 flag clear, 2 status |
| wr_data_i | input | DATA_W | Register write data |
| take_o | output | 1 | Take-interrupt strobe, one cycle |
| vector_o | output | ADDR_W | Word address of the vector slot |
| pend_o | output | NUM_SRC | Pending flags |
| enable_o | output | NUM_SRC | Per-source enable mask |
| gie_o | output | 1 | Global enable |

## Verification
Two cases are hard to reach from the ports because each needs two events to land on the same clock edge. One is an acceptance coinciding with a software status write that sets the global enable. The other is a flag set pulse coinciding with a write-one clear of the same flag. The bench reaches both by staging the flag one cycle ahead and then driving the write on the exact falling edge before the acceptance edge. The re-enable latency after a return is checked by sampling the strobe one cycle after `reti_i` while a source is already pending. Expected vectors go into a scoreboard queue, and any strobe with no queued entry is reported.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    REG_ENABLE  = 2'd0,
    REG_FLAGCLR = 2'd1,
    REG_STATUS  = 2'd2,
    REG_UNUSED  = 2'd3
  } irq_reg_e;

  localparam int GIE_BIT = 7;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = 20,
  parameter logic [NUM_SRC-1:0] AUTO_CLR = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] sw_clr_i,
  input  logic               svc_i,
  input  logic [NUM_SRC-1:0] svc_onehot_i,
  output logic [NUM_SRC-1:0] flags_o
);
  logic [NUM_SRC-1:0] hw_clr;
  logic [NUM_SRC-1:0] flags_q;

  assign hw_clr  = svc_i ? (svc_onehot_i & AUTO_CLR) : '0;
  assign flags_o = flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~sw_clr_i & ~hw_clr) | set_i;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_SRC = 20,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_SRC-1:0] onehot_o
);
  function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_SRC-1:0] r);
    logic [IDX_W-1:0] res;
    res = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (r[i]) res = IDX_W'(i);
    return res;
  endfunction

  assign any_o = |req_i;
  assign idx_o = lowest_set(req_i);

  always_comb begin
    onehot_o = '0;
    if (any_o) onehot_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               accept_i,
  input  logic               reti_i,
  output logic [NUM_SRC-1:0] enable_o,
  output logic [NUM_SRC-1:0] sw_clr_o,
  output logic               gie_o
);
  logic               wr_en_sel, wr_clr_sel, wr_sts_sel;
  logic [NUM_SRC-1:0] en_q;
  logic               gie_q;

  assign wr_en_sel  = wr_en_i && (irq_reg_e'(wr_addr_i) == REG_ENABLE);
  assign wr_clr_sel = wr_en_i && (irq_reg_e'(wr_addr_i) == REG_FLAGCLR);
  assign wr_sts_sel = wr_en_i && (irq_reg_e'(wr_addr_i) == REG_STATUS);

  assign sw_clr_o = wr_clr_sel ? wr_data_i[NUM_SRC-1:0] : '0;
  assign enable_o = en_q;
  assign gie_o    = gie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      if (wr_en_sel) en_q <= wr_data_i[NUM_SRC-1:0];
      if (accept_i)        gie_q <= 1'b0;
      else if (reti_i)     gie_q <= 1'b1;
      else if (wr_sts_sel) gie_q <= wr_data_i[GIE_BIT];
    end
  end

  // R9
  reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !accept_i) |=> gie_o);
  // R6
  accept_drops_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> !gie_o);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NUM_SRC    = 20,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 2,
  parameter int VEC_STRIDE = 2,
  parameter logic [NUM_SRC-1:0] AUTO_CLR = NUM_SRC'(256)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flag_set_i,
  input  logic               boundary_i,
  input  logic               reti_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               take_o,
  output logic [ADDR_W-1:0]  vector_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] enable_o,
  output logic               gie_o
);
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int VEC_TOP = VEC_BASE + VEC_STRIDE * (NUM_SRC - 1);

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [IDX_W-1:0] idx);
    return ADDR_W'(VEC_BASE + VEC_STRIDE * int'(idx));
  endfunction

  logic [NUM_SRC-1:0] flags, en_mask, sw_clr, eligible, win_onehot;
  logic [IDX_W-1:0]   win_idx;
  logic               win_any, gie, accept;
  logic               take_q;
  logic [ADDR_W-1:0]  vec_q;

  assign eligible = gie ? (flags & en_mask) : '0;
  assign accept   = boundary_i && win_any;

  irq_ctrl_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .accept_i(accept), .reti_i(reti_i),
    .enable_o(en_mask), .sw_clr_o(sw_clr), .gie_o(gie)
  );

  irq_flag_bank #(.NUM_SRC(NUM_SRC), .AUTO_CLR(AUTO_CLR)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_i(flag_set_i), .sw_clr_i(sw_clr),
    .svc_i(accept), .svc_onehot_i(win_onehot),
    .flags_o(flags)
  );

  irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .req_i(eligible), .any_o(win_any), .idx_o(win_idx), .onehot_o(win_onehot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= accept;
      if (accept) vec_q <= slot_addr(win_idx);
    end
  end

  assign take_o   = take_q;
  assign vector_o = vec_q;
  assign pend_o   = flags;
  assign enable_o = en_mask;
  assign gie_o    = gie;

  // R6
  gie_clear_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !gie_o);
  // R5
  take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);
  // R5
  vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (int'(vector_o) >= VEC_BASE && int'(vector_o) <= VEC_TOP));
  // R3
  take_needs_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i));
  // R2
  take_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($past(gie_o) && ($past(pend_o & enable_o) != '0)));
  // R4
  winner_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_any |-> (eligible[win_idx] && ((eligible & ((NUM_SRC'(1) << win_idx) - NUM_SRC'(1))) == '0)));
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  localparam int N = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  flag_set_i = '0;
  logic          boundary_i = 1'b1;
  logic          reti_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_addr_i = '0;
  logic [31:0]   wr_data_i = '0;
  logic          take_o;
  logic [15:0]   vector_o;
  logic [N-1:0]  pend_o, enable_o;
  logic          gie_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .flag_set_i(flag_set_i), .boundary_i(boundary_i),
    .reti_i(reti_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .take_o(take_o), .vector_o(vector_o), .pend_o(pend_o), .enable_o(enable_o),
    .gie_o(gie_o)
  );

  function automatic int slot_of(int k);
    return 2 + k * 2;
  endfunction

  task automatic check_eq(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_slot(int k);
    exp_q.push_back(slot_of(k));
  endtask

  // monitor: every strobe must match the head of the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && take_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2/R3: unexpected take, actual vector 0x%0h expected none", vector_o);
      end else begin
        check_eq("R5 vector", vector_o, exp_q.pop_front());
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_set(logic [N-1:0] m);
    flag_set_i = m;
    @(negedge clk);
    flag_set_i = '0;
  endtask

  task automatic reti();
    reti_i = 1'b1;
    @(negedge clk);
    reti_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check_eq("R1 gie", gie_o, 0);
    check_eq("R1 enable", enable_o, 0);
    check_eq("R1 pend", pend_o, 0);
    check_eq("R1 take", take_o, 0);

    // R2: flag pending but not enabled, gie off -> nothing
    pulse_set(N'(1) << 3);
    idle(3);
    check_eq("R2 pend held", pend_o, N'(1) << 3);
    // R10 enable mask and status writes
    wr(2'd0, 32'h000F_FFFF);
    check_eq("R10 enable", enable_o, 20'hFFFFF);
    idle(2);
    expect_slot(3);
    wr(2'd2, 32'h80);
    idle(3);
    // R6 gie cleared, R7 non-auto flag stays
    check_eq("R6 gie after take", gie_o, 0);
    check_eq("R7 flag3 kept", pend_o[3], 1);
    check_eq("R2 queue drained", exp_q.size(), 0);
    // R8 W1C
    wr(2'd1, 32'h8);
    check_eq("R8 w1c", pend_o, 0);
    // R8 set wins over clear in the same cycle (gie off)
    flag_set_i = N'(1) << 4;
    wr(2'd1, 32'h10);
    flag_set_i = '0;
    check_eq("R8 set wins", pend_o, N'(1) << 4);
    wr(2'd1, 32'h10);
    check_eq("R8 cleared", pend_o, 0);

    // R4 priority: 5 and 12 together, gie off
    pulse_set((N'(1) << 5) | (N'(1) << 12));
    expect_slot(5);
    reti();
    check_eq("R9 gie set", gie_o, 1);
    idle(3);
    wr(2'd1, 32'h20);
    // R9 re-enable latency: take not before the edge after reti
    expect_slot(12);
    reti_i = 1'b1;
    @(negedge clk);
    reti_i = 1'b0;
    check_eq("R9 gie", gie_o, 1);
    check_eq("R9 no early take", take_o, 0);
    @(negedge clk);
    check_eq("R9 take next", take_o, 1);
    wr(2'd1, 32'h1000);

    // R7 auto-clear source 8
    expect_slot(8);
    reti();
    pulse_set(N'(1) << 8);
    idle(3);
    check_eq("R7 auto cleared", pend_o[8], 0);

    // R3 boundary gating
    boundary_i = 1'b0;
    reti();
    pulse_set(N'(1) << 0);
    idle(4);
    check_eq("R3 waits", gie_o, 1);
    expect_slot(0);
    boundary_i = 1'b1;
    idle(3);
    wr(2'd1, 32'h1);

    // R2 per-source enable off for 19
    wr(2'd0, 32'h0007_FFFF);
    reti();
    pulse_set(N'(1) << 19);
    idle(4);
    check_eq("R2 masked src", gie_o, 1);
    expect_slot(19);
    wr(2'd0, 32'h000F_FFFF);
    idle(3);
    check_eq("R5 last slot", slot_of(19), 16'h28);
    wr(2'd1, 32'h80000);

    // R6 acceptance overrides a simultaneous status write
    wr(2'd2, 32'h80);
    boundary_i = 1'b0;
    pulse_set(N'(1) << 2);
    expect_slot(2);
    boundary_i = 1'b1;
    wr(2'd2, 32'h80);
    check_eq("R6 gie over write", gie_o, 0);
    idle(3);
    check_eq("R6 queue empty", exp_q.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule